// File: doc/BRIEF.md
# Battery-Domain RTC Clock Control Register

This block is a single 32-bit control register that lives in a battery-backed power domain. It sets the clock source for the real-time clock and controls the low-speed external crystal oscillator: its enable, its bypass, and its ready flag. Software reaches it over a simple valid/ready bus that carries byte-lane strobes, so byte, half-word and word writes all work.

The contents persist across ordinary system resets. Only the domain power-on reset clears them. A second way to clear the domain is a software reset bit held inside the register. An external write-enable input must be high before software can change the oscillator and clock fields. The source-select field can be written once. After that it keeps its value until the next domain reset.

The select output drives a four-way RTC clock multiplexer that sits outside this block. The oscillator itself and the divider for the high-speed source are also outside. The bus pays a fixed wait penalty when accesses to the register come back to back.

Top module: `rtc_bkp_ctl`

## Requirements
- R1: The power-on reset input (`porRstN` low) clears every register bit, the ready-flag synchronizer and the select lock. The system reset input (`sysRstN`) leaves all register contents unchanged.
- R2: The register layout is as follows. Bit 0 is the oscillator enable. Bit 1 is the read-only ready flag. Bit 2 is the oscillator bypass. Bits 9:8 are the source select (00 none, 01 low-speed external, 10 low-speed internal, 11 divided high-speed external). Bit 15 is the RTC clock enable. Bit 16 is the software domain reset. All other bits read as 0.
- R3: When `domWrEn` is low, writes to bits 0, 2, 9:8 and 15 are dropped. Bit 16 is writable whatever the state of `domWrEn`.
- R4: The first write of a nonzero value to bits 9:8 locks the field. Later writes to bits 9:8 are ignored until a domain reset (R1 or R5) occurs.
- R5: While bit 16 reads 1, `domRst` is high. On the following clock, bits 0, 2, 9:8 and 15 and the lock are cleared, and any field write made while bit 16 is set is dropped. This includes a write that clears bit 16 in the same access.
- R6: Bit 1 reads as `oscStable` after a two-flop synchronizer. It reads 0 whenever bit 0 is 0.
- R7: Each byte-lane strobe gates only its own byte. `busStrb[0]` covers bits 7:0, `busStrb[1]` covers bits 15:8 and `busStrb[2]` covers bits 23:16.
- R8: An access whose previous cycle completed no access to the register is accepted with `busReady` high in the same cycle. An access that directly follows a completed access sees `busReady` low for 2 cycles and completes in the third.
- R9: `oscEnable`, `oscBypass`, `rtcSrcSel` and `rtcClkEn` always equal register bits 0, 2, 9:8 and 15.
- R10: The register responds only at word address `0x70` (with `busAddr[1:0]` equal to 0). Other addresses return 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| porRstN | input | 1 | Domain power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low; affects only the bus wait logic |
| busValid | input | 1 | Access request, held until `busReady` |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte-lane write strobes |
| busRdata | output | 32 | Read data, valid while `busReady` is high |
| busReady | output | 1 | Access completes in a cycle where this is high |
| domWrEn | input | 1 | Domain write enable for the guarded fields |
| oscStable | input | 1 | Asynchronous oscillator-stable indication |
| oscEnable | output | 1 | Oscillator enable |
| oscBypass | output | 1 | Oscillator bypass |
| rtcSrcSel | output | 2 | RTC clock multiplexer select |
| rtcClkEn | output | 1 | RTC clock enable |
| domRst | output | 1 | Software domain reset, held while bit 16 is set |

## Verification
A field write and a pending software domain reset can land in the same clock. The bench provokes this by setting bit 16 and then issuing full-word writes that carry field values. One of these writes also clears bit 16 in the same access. It judges the outcome from the read-back: the fields stay zero, bit 16 follows the written value, and only a later write after release takes effect. The lock is released at that point.

// File: rtl/rtc_bkp_pkg.sv
package rtc_bkp_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int BIT_OSCEN = 0;
  localparam int BIT_RDY   = 1;
  localparam int BIT_BYP   = 2;
  localparam int BIT_SEL   = 8;
  localparam int SEL_W     = 2;
  localparam int BIT_RTCEN = 15;
  localparam int BIT_SWRST = 16;

  typedef struct packed {
    logic wrLane2;
    logic wrLane1;
    logic wrLane0;
  } bdcStrobe_t;
endpackage

// File: rtl/rtc_bkp_ctrl.sv
module rtc_bkp_ctrl
  import rtc_bkp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h70,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busStrb,
  output logic              busReady,
  output logic              regHit,
  output bdcStrobe_t        stb
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  logic             prevDoneQ;
  logic [CNT_W-1:0] waitQ;
  logic             stall;
  logic             accDone;
  logic             wrDone;
  logic             unusedStrb;

  assign regHit   = (busAddr == REG_OFF);
  assign stall    = regHit && (prevDoneQ || (waitQ != '0));
  assign busReady = !(busValid && stall);
  assign accDone  = busValid && regHit && busReady;
  assign wrDone   = accDone && busWrite;

  assign stb.wrLane0 = wrDone && busStrb[0];
  assign stb.wrLane1 = wrDone && busStrb[1];
  assign stb.wrLane2 = wrDone && busStrb[2];
  assign unusedStrb  = ^busStrb[LANES-1:3];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      prevDoneQ <= 1'b0;
      waitQ     <= '0;
    end else begin
      prevDoneQ <= accDone;
      if (busValid && regHit && prevDoneQ && (waitQ == '0))
        waitQ <= CNT_LOAD;
      else if (waitQ != '0)
        waitQ <= waitQ - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bkp_dpath.sv
module rtc_bkp_dpath
  import rtc_bkp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  bdcStrobe_t        stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              domWrEn,
  input  logic              oscStable,
  output logic [DATA_W-1:0] regVal,
  output logic              oscEnable,
  output logic              oscBypass,
  output logic [SEL_W-1:0]  rtcSrcSel,
  output logic              rtcClkEn,
  output logic              domRst,
  output logic              selLocked
);
  logic                   oscEnQ, bypQ, rtcEnQ, swRstQ, lockQ;
  logic [SEL_W-1:0]       selQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rdyFlag;
  logic                   unusedWdata;

  assign unusedWdata = ^{busWdata[DATA_W-1:BIT_SWRST+1],
                         busWdata[BIT_RTCEN-1:BIT_SEL+SEL_W],
                         busWdata[BIT_SEL-1:BIT_BYP+1],
                         busWdata[BIT_RDY]};

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], oscStable};
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      oscEnQ <= 1'b0;
      bypQ   <= 1'b0;
      selQ   <= '0;
      lockQ  <= 1'b0;
      rtcEnQ <= 1'b0;
      swRstQ <= 1'b0;
    end else begin
      if (stb.wrLane2) swRstQ <= busWdata[BIT_SWRST];
      if (swRstQ) begin
        oscEnQ <= 1'b0;
        bypQ   <= 1'b0;
        selQ   <= '0;
        lockQ  <= 1'b0;
        rtcEnQ <= 1'b0;
      end else if (domWrEn) begin
        if (stb.wrLane0) begin
          oscEnQ <= busWdata[BIT_OSCEN];
          bypQ   <= busWdata[BIT_BYP];
        end
        if (stb.wrLane1) begin
          rtcEnQ <= busWdata[BIT_RTCEN];
          if (!lockQ) begin
            selQ <= busWdata[BIT_SEL +: SEL_W];
            if (busWdata[BIT_SEL +: SEL_W] != '0) lockQ <= 1'b1;
          end
        end
      end
    end
  end

  assign rdyFlag = syncQ[SYNC_STAGES-1] && oscEnQ;

  always_comb begin
    regVal                   = '0;
    regVal[BIT_OSCEN]        = oscEnQ;
    regVal[BIT_RDY]          = rdyFlag;
    regVal[BIT_BYP]          = bypQ;
    regVal[BIT_SEL +: SEL_W] = selQ;
    regVal[BIT_RTCEN]        = rtcEnQ;
    regVal[BIT_SWRST]        = swRstQ;
  end

  assign oscEnable = oscEnQ;
  assign oscBypass = bypQ;
  assign rtcSrcSel = selQ;
  assign rtcClkEn  = rtcEnQ;
  assign domRst    = swRstQ;
  assign selLocked = lockQ;
endmodule

// File: rtl/rtc_bkp_ctl.sv
module rtc_bkp_ctl
  import rtc_bkp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h70,
  parameter int WAIT_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busStrb,
  output logic [31:0]       busRdata,
  output logic              busReady,
  input  logic              domWrEn,
  input  logic              oscStable,
  output logic              oscEnable,
  output logic              oscBypass,
  output logic [1:0]        rtcSrcSel,
  output logic              rtcClkEn,
  output logic              domRst
);
  bdcStrobe_t        stb;
  logic              regHit;
  logic              selLocked;
  logic [DATA_W-1:0] regVal;

  rtc_bkp_ctrl #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busStrb(busStrb), .busReady(busReady),
    .regHit(regHit), .stb(stb)
  );

  rtc_bkp_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .porRstN(porRstN), .stb(stb), .busWdata(busWdata),
    .domWrEn(domWrEn), .oscStable(oscStable), .regVal(regVal),
    .oscEnable(oscEnable), .oscBypass(oscBypass), .rtcSrcSel(rtcSrcSel),
    .rtcClkEn(rtcClkEn), .domRst(domRst), .selLocked(selLocked)
  );

  assign busRdata = (busValid && regHit) ? regVal : '0;
endmodule

// File: rtl/rtc_bkp_ctl_chk.sv
module rtc_bkp_ctl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h70
) (
  input logic              clk,
  input logic              porRstN,
  input logic              sysRstN,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              busReady,
  input logic              domWrEn,
  input logic              oscEnable,
  input logic              oscBypass,
  input logic [1:0]        rtcSrcSel,
  input logic              rtcClkEn,
  input logic              domRst,
  input logic              selLocked
);
  logic hitC;
  assign hitC = (busAddr == REG_OFF);

  p_sel_frozen_r4: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (selLocked && !domRst) |=> $stable(rtcSrcSel));

  p_swrst_clears_r5: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    domRst |=> (rtcSrcSel == 2'b00 && !oscEnable && !oscBypass && !rtcClkEn && !selLocked));

  p_gate_drop_r3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (!domWrEn && !domRst) |=> $stable({oscEnable, oscBypass, rtcSrcSel, rtcClkEn}));

  p_b2b_stall_r8: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    ($past(busValid && busReady && hitC) && busValid && hitC) |-> !busReady);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (busRdata & 32'hFFFE_7CF8) == 32'h0);

  p_ready_needs_en_r6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    busRdata[1] |-> busRdata[0]);
endmodule

bind rtc_bkp_ctl rtc_bkp_ctl_chk #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busValid(busValid),
  .busAddr(busAddr), .busRdata(busRdata), .busReady(busReady), .domWrEn(domWrEn),
  .oscEnable(oscEnable), .oscBypass(oscBypass), .rtcSrcSel(rtcSrcSel),
  .rtcClkEn(rtcClkEn), .domRst(domRst), .selLocked(selLocked)
);

// File: tb/rtc_bkp_ctl_bench.sv
module rtc_bkp_ctl_bench;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0, sysRstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h70;
  logic [31:0] busWdata = '0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        domWrEn = 1'b0, oscStable = 1'b0;
  logic        oscEnable, oscBypass, rtcClkEn, domRst;
  logic [1:0]  rtcSrcSel;
  int          nChk = 0, nFail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rtc_bkp_ctl u_rtc_bkp_ctl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .busStrb(busStrb),
    .busRdata(busRdata), .busReady(busReady), .domWrEn(domWrEn), .oscStable(oscStable),
    .oscEnable(oscEnable), .oscBypass(oscBypass), .rtcSrcSel(rtcSrcSel),
    .rtcClkEn(rtcClkEn), .domRst(domRst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd);
    @(negedge clk); @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busStrb = s;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    rd = busRdata;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0; busAddr = 8'h70;
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    logic [31:0] dummy;
    access(1'b1, 8'h70, d, s, dummy);
  endtask

  task automatic rdChk(input string req, input logic [31:0] exp);
    logic [31:0] v;
    access(1'b0, 8'h70, '0, '0, v);
    chk(req, v, exp);
  endtask

  task automatic testReset();
    rdChk("R1 power-on value", 32'h0);
    chk("R9 outputs after reset", {27'b0, oscEnable, oscBypass, rtcSrcSel, rtcClkEn}, 32'h0);
  endtask

  task automatic testGate();
    domWrEn = 1'b0;
    wr(32'h0000_8305, 4'hF);
    rdChk("R3 gated write dropped", 32'h0);
    wr(32'h0001_0000, 4'h4);
    chk("R3 bit16 ungated", {31'b0, domRst}, 32'h1);
    wr(32'h0, 4'h4);
    chk("R3 bit16 release", {31'b0, domRst}, 32'h0);
  endtask

  task automatic testLayout();
    domWrEn = 1'b1;
    wr(32'h0000_8105, 4'hF);
    rdChk("R2 field layout", 32'h0000_8105);
    chk("R9 outputs mirror", {27'b0, oscEnable, oscBypass, rtcSrcSel, rtcClkEn}, 32'h1B);
  endtask

  task automatic testLock();
    wr(32'h0000_0205, 4'hF);
    rdChk("R4 select locked", 32'h0000_0105);
    chk("R4 select output", {30'b0, rtcSrcSel}, 32'h1);
  endtask

  task automatic testSysRst();
    @(negedge clk); sysRstN = 1'b0;
    repeat (3) @(negedge clk);
    sysRstN = 1'b1;
    rdChk("R1 system reset keeps contents", 32'h0000_0105);
  endtask

  task automatic testReady();
    @(negedge clk); oscStable = 1'b1;
    repeat (4) @(negedge clk);
    rdChk("R6 ready flag set", 32'h0000_0107);
    wr(32'h0000_0004, 4'h1);
    rdChk("R6 ready forced low", 32'h0000_0104);
  endtask

  task automatic testLanes();
    wr(32'hFFFF_FFFF, 4'h2);
    rdChk("R7 lane1 only", 32'h0000_8104);
    wr(32'hFFFF_0001, 4'h1);
    rdChk("R7 lane0 only", 32'h0000_8103);
  endtask

  task automatic testSwReset();
    wr(32'h0001_0000, 4'h4);
    rdChk("R5 fields cleared under reset", 32'h0001_0000);
    chk("R5 domRst high", {31'b0, domRst}, 32'h1);
    wr(32'h0001_8205, 4'h7);
    rdChk("R5 write dropped while set", 32'h0001_0000);
    wr(32'h0000_0101, 4'hF);
    rdChk("R5 same-access release drops fields", 32'h0);
    wr(32'h0000_0200, 4'h2);
    rdChk("R4 lock freed by software reset", 32'h0000_0200);
  endtask

  task automatic testWait();
    @(negedge clk); @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 8'h70; busStrb = '0;
    #1; chk("R8 lone access ready", {31'b0, busReady}, 32'h1);
    @(posedge clk); #1;
    chk("R8 stall cycle 1", {31'b0, busReady}, 32'h0);
    @(posedge clk); #1;
    chk("R8 stall cycle 2", {31'b0, busReady}, 32'h0);
    @(posedge clk); #1;
    chk("R8 completes third", {31'b0, busReady}, 32'h1);
    chk("R8 data on completion", busRdata, 32'h0000_0200);
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic testAddr();
    logic [31:0] v;
    access(1'b1, 8'h74, 32'hFFFF_FFFF, 4'hF, v);
    rdChk("R10 other address no effect", 32'h0000_0200);
    access(1'b0, 8'h74, '0, '0, v);
    chk("R10 other address reads zero", v, 32'h0);
  endtask

  task automatic testPor();
    @(negedge clk); porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    rdChk("R1 power-on clears", 32'h0);
    wr(32'h0000_0100, 4'h2);
    rdChk("R1 lock cleared by power-on", 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1; sysRstN = 1'b1;
    testReset();
    testGate();
    testLayout();
    testLock();
    testSysRst();
    testReady();
    testLanes();
    testSwReset();
    testWait();
    testAddr();
    testPor();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule